// File: doc/BRIEF.md
# Floppy Controller Host Register Bank

This block is the host-facing register set of a single-drive floppy disk controller. It occupies eight byte offsets. It holds the drive-control byte, the tape select, the data-rate and precompensation settings, and the status views that report drive-interface activity. Three interface modes are supported: AT, PS/2 and Model 30. Each mode changes which offsets return data and how the status bits are laid out and polarised. The block also produces the controller-wide software reset, the low-power flag and the effective data rate. The command FIFO and the main status register sit elsewhere, and the host's accesses to them reach this block only as a strobe.

The drive-interface inputs are active-high levels. Each one passes through a two-stage synchroniser on the system clock before any edge is detected. A small control state machine decides whether the controller is held in reset, pulsed into reset, running or dozing. Its states are:

- `CS_HOLD`: the drive-control reset bit is 0.
- `CS_PULSE`: a one-cycle reset requested through the rate register.
- `CS_RUN`: normal operation.
- `CS_DOZE`: manual low power.

Its transitions are:

- Any state goes to `CS_HOLD` whenever the next drive-control reset bit is 0.
- Otherwise, any state goes to `CS_PULSE` on a rate-register write with bit 7 set.
- `CS_HOLD` and `CS_PULSE` return to `CS_RUN`.
- `CS_RUN` goes to `CS_DOZE` on a rate-register write with bit 6 set.
- `CS_DOZE` goes back to `CS_RUN` on a FIFO or main-status access strobe.

Offset map: 0 status A (read), 1 status B (read), 2 drive control (read/write), 3 tape select (read/write), 4 rate select (write), 7 configuration control (write) and disk input (read). Offsets 4, 5 and 6 never drive read data. `mode` encodes 0 = AT, 1 = PS/2, 2 = Model 30; the value 3 behaves as AT.

Top module: `fdc_hostregs`

## Requirements
- R1: After hardware reset, the drive-control byte is 00h and the controller reset output is asserted. Also after reset: data rate 2'b10, precompensation 3'b000, low power off, tape select 0, and all status toggles and latches 0.
- R2: Writing 0 to drive-control bit 2 holds `ctl_reset` high until a write sets that bit back to 1. The rate, precompensation, tape select and the other drive-control bits keep their values.
- R3: A write to offset 4 with bit 7 set raises `ctl_reset` for exactly one cycle, starting after the write edge, and the bit does not persist.
- R4: `data_rate` equals bits 1:0 of the most recent write to offset 4 or offset 7. `precomp` takes bits 4:2 of writes to offset 4 only.
- R5: A write to offset 4 with bit 6 set raises `low_power`. It falls after the next `fifo_acc` strobe or any software reset, and never overlaps `ctl_reset`.
- R6: In PS/2 mode, status B reads as follows:
  - bit 3 toggles on each falling edge of the read-data pin;
  - bit 4 toggles on each falling edge of the write-data pin;
  - bit 2 shows the write-gate level;
  - bit 5 shows drive-control bit 0;
  - bits 1:0 show drive-control bits 5:4;
  - bits 7:6 read 1.
- R7: In Model 30 mode, status B bits 0, 1 and 2 latch the write-gate rising edge, the read-data falling edge and the write-data falling edge. Status A bit 5 latches the step rising edge. All four latches clear on a read of offset 7 or during `ctl_reset`.
- R8: In PS/2 mode, status A bits 4:0 read {not track0, head select, not index, not write protect, direction}. Model 30 mode inverts all five. Bit 7 shows `int_req` and bit 6 shows `dma_req`. In PS/2 mode bit 5 shows the step level.
- R9: `rdata_oe` stays low, with `rdata` 00h, for reads of offsets 0 and 1 in AT mode, and for offsets 4, 5 and 6 in every mode.
- R10: A read of offset 7 returns 0 in bits 6:0. Bit 7 returns the inverse of the disk-change pin, or `dchg_force_val` when `dchg_force_en` is high.
- R11: Offset 3 reads 0 in bits 7:2 and the stored tape select in bits 1:0, and a software reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| mode | input | 2 | Interface mode: 0 AT, 1 PS/2, 2 Model 30 |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data is driven |
| fifo_acc | input | 1 | Data register or main status access strobe |
| int_req | input | 1 | Controller interrupt level |
| dma_req | input | 1 | Controller DMA request level |
| drv_dir | input | 1 | Step direction pin |
| drv_wprot | input | 1 | Write protect pin |
| drv_index | input | 1 | Index pin |
| drv_hdsel | input | 1 | Head select pin |
| drv_trk0 | input | 1 | Track 0 pin |
| drv_step | input | 1 | Step pin |
| drv_rdpulse | input | 1 | Read data pulse pin |
| drv_wrpulse | input | 1 | Write data pulse pin |
| drv_wgate | input | 1 | Write gate pin |
| drv_dskchg | input | 1 | Disk change pin |
| dchg_force_en | input | 1 | Use forced disk-change value |
| dchg_force_val | input | 1 | Forced disk-change read value |
| dor_bits | output | 8 | Drive-control byte |
| ctl_reset | output | 1 | Controller software reset |
| low_power | output | 1 | Manual low-power state |
| data_rate | output | 2 | Effective data rate code |
| precomp | output | 3 | Precompensation code |

## Verification
The properties assume the following about the host side:
- At most one access per cycle.
- Strobes and data held stable across a rising edge.
- `wr_en` held low during hardware reset, so that the history sampled just after reset is clean.

The bench keeps to this by changing every strobe and pin only at falling clock edges, one access per task call. Pin pulses are held at least four cycles on each level so that every edge survives the two-stage synchroniser. No drive-pin edge is placed in the same cycle as a disk-input read.

// File: rtl/fdc_reg_pkg.sv
package fdc_reg_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int RATE_W    = 2;
    localparam int PRECOMP_W = 3;
    localparam int TAPE_W    = 2;

    localparam logic [ADDR_W-1:0] OFF_SRA = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_SRB = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_DOR = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_TDR = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_DSR = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_DIR = 3'd7;

    localparam logic [1:0] MODE_AT  = 2'd0;
    localparam logic [1:0] MODE_PS2 = 2'd1;
    localparam logic [1:0] MODE_M30 = 2'd2;

    localparam int PIN_DIR  = 0;
    localparam int PIN_WP   = 1;
    localparam int PIN_IDX  = 2;
    localparam int PIN_HDS  = 3;
    localparam int PIN_TRK0 = 4;
    localparam int PIN_STEP = 5;
    localparam int PIN_RD   = 6;
    localparam int PIN_WR   = 7;
    localparam int PIN_WG   = 8;
    localparam int PIN_DCHG = 9;
    localparam int NPIN     = 10;

    typedef enum logic [1:0] {
        CS_HOLD  = 2'd0,
        CS_PULSE = 2'd1,
        CS_RUN   = 2'd2,
        CS_DOZE  = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/fdc_pin_sync.sv
module fdc_pin_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] stg;
    logic [W-1:0]             prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg  <= '0;
            prev <= '0;
        end else begin
            stg[0] <= pins;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign lvl = stg[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise[b] = lvl[b] & ~prev[b];
        assign fall[b] = ~lvl[b] & prev[b];
    end
endmodule

// File: rtl/fdc_status_trk.sv
module fdc_status_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rd_fall,
    input  logic wr_fall,
    input  logic wg_rise,
    input  logic step_rise,
    output logic rd_tog,
    output logic wr_tog,
    output logic wg_lat,
    output logic rd_lat,
    output logic wr_lat,
    output logic step_lat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_tog <= 1'b0;
            wr_tog <= 1'b0;
        end else begin
            if (rd_fall) rd_tog <= ~rd_tog;
            if (wr_fall) wr_tog <= ~wr_tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wg_lat   <= 1'b0;
            rd_lat   <= 1'b0;
            wr_lat   <= 1'b0;
            step_lat <= 1'b0;
        end else begin
            wg_lat   <= wg_rise   | (wg_lat   & ~clr);
            rd_lat   <= rd_fall   | (rd_lat   & ~clr);
            wr_lat   <= wr_fall   | (wr_lat   & ~clr);
            step_lat <= step_rise | (step_lat & ~clr);
        end
    end
endmodule

// File: rtl/fdc_ctl_fsm.sv
module fdc_ctl_fsm
    import fdc_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_nxt,
    input  logic pulse_req,
    input  logic doze_req,
    input  logic wake,
    output logic ctl_reset,
    output logic low_power
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!run_nxt) begin
            state_d = CS_HOLD;
        end else if (pulse_req) begin
            state_d = CS_PULSE;
        end else begin
            unique case (state_q)
                CS_HOLD:  state_d = CS_RUN;
                CS_PULSE: state_d = CS_RUN;
                CS_RUN:   state_d = doze_req ? CS_DOZE : CS_RUN;
                CS_DOZE:  state_d = wake ? CS_RUN : CS_DOZE;
                default:  state_d = CS_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        ctl_reset = 1'b0;
        low_power = 1'b0;
        unique case (state_q)
            CS_HOLD:  ctl_reset = 1'b1;
            CS_PULSE: ctl_reset = 1'b1;
            CS_RUN:   ;
            CS_DOZE:  low_power = 1'b1;
            default:  ctl_reset = 1'b1;
        endcase
    end
endmodule

// File: rtl/fdc_hostregs.sv
module fdc_hostregs
    import fdc_reg_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [RATE_W-1:0]  RATE_RST    = 2'b10,
    parameter logic [PRECOMP_W-1:0] PRECOMP_RST = 3'b000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_oe,
    input  logic                 fifo_acc,
    input  logic                 int_req,
    input  logic                 dma_req,
    input  logic                 drv_dir,
    input  logic                 drv_wprot,
    input  logic                 drv_index,
    input  logic                 drv_hdsel,
    input  logic                 drv_trk0,
    input  logic                 drv_step,
    input  logic                 drv_rdpulse,
    input  logic                 drv_wrpulse,
    input  logic                 drv_wgate,
    input  logic                 drv_dskchg,
    input  logic                 dchg_force_en,
    input  logic                 dchg_force_val,
    output logic [DATA_W-1:0]    dor_bits,
    output logic                 ctl_reset,
    output logic                 low_power,
    output logic [RATE_W-1:0]    data_rate,
    output logic [PRECOMP_W-1:0] precomp
);
    localparam int TAPE_PAD = DATA_W - TAPE_W;

    logic [NPIN-1:0] pins, lvl, rise, fall;
    assign pins = {drv_dskchg, drv_wgate, drv_wrpulse, drv_rdpulse, drv_step,
                   drv_trk0, drv_hdsel, drv_index, drv_wprot, drv_dir};

    fdc_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .pins (pins),
        .lvl (lvl),
        .rise (rise),
        .fall (fall)
    );

    logic wr_dor, wr_tdr, wr_dsr, wr_ccr, rd_dir;
    assign wr_dor = wr_en && (addr == OFF_DOR);
    assign wr_tdr = wr_en && (addr == OFF_TDR);
    assign wr_dsr = wr_en && (addr == OFF_DSR);
    assign wr_ccr = wr_en && (addr == OFF_DIR);
    assign rd_dir = rd_en && (addr == OFF_DIR);

    logic [DATA_W-1:0]    dor_q;
    logic [TAPE_W-1:0]    tdr_q;
    logic [RATE_W-1:0]    rate_q;
    logic [PRECOMP_W-1:0] pcomp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dor_q   <= '0;
            tdr_q   <= '0;
            rate_q  <= RATE_RST;
            pcomp_q <= PRECOMP_RST;
        end else begin
            if (wr_dor) dor_q <= wdata;
            if (wr_tdr) tdr_q <= wdata[TAPE_W-1:0];
            if (wr_dsr || wr_ccr) rate_q <= wdata[RATE_W-1:0];
            if (wr_dsr) pcomp_q <= wdata[RATE_W+PRECOMP_W-1:RATE_W];
        end
    end

    fdc_ctl_fsm u_fsm (
        .clk (clk),
        .rst_n (rst_n),
        .run_nxt (wr_dor ? wdata[2] : dor_q[2]),
        .pulse_req (wr_dsr & wdata[7]),
        .doze_req (wr_dsr & wdata[6]),
        .wake (fifo_acc),
        .ctl_reset (ctl_reset),
        .low_power (low_power)
    );

    logic rd_tog, wr_tog, wg_lat, rd_lat, wr_lat, step_lat;

    fdc_status_trk u_trk (
        .clk (clk),
        .rst_n (rst_n),
        .clr (rd_dir | ctl_reset),
        .rd_fall (fall[PIN_RD]),
        .wr_fall (fall[PIN_WR]),
        .wg_rise (rise[PIN_WG]),
        .step_rise (rise[PIN_STEP]),
        .rd_tog (rd_tog),
        .wr_tog (wr_tog),
        .wg_lat (wg_lat),
        .rd_lat (rd_lat),
        .wr_lat (wr_lat),
        .step_lat (step_lat)
    );

    logic unused_edges;
    assign unused_edges = ^{rise[PIN_DCHG], rise[PIN_WR], rise[PIN_RD], rise[4:0],
                            fall[PIN_DCHG], fall[PIN_WG], fall[PIN_STEP], fall[4:0],
                            lvl[PIN_WR], lvl[PIN_RD]};

    logic [4:0]        sra_low;
    logic [DATA_W-1:0] sra_ps2, sra_m30, srb_ps2, srb_m30, dir_val;

    assign sra_low = {~lvl[PIN_TRK0], lvl[PIN_HDS], ~lvl[PIN_IDX], ~lvl[PIN_WP], lvl[PIN_DIR]};
    assign sra_ps2 = {int_req, dma_req, lvl[PIN_STEP], sra_low};
    assign sra_m30 = {int_req, dma_req, step_lat, ~sra_low};
    assign srb_ps2 = {2'b11, dor_q[0], wr_tog, rd_tog, lvl[PIN_WG], dor_q[5], dor_q[4]};
    assign srb_m30 = {5'b00000, wr_lat, rd_lat, wg_lat};
    assign dir_val = {(dchg_force_en ? dchg_force_val : ~lvl[PIN_DCHG]), 7'b0000000};

    logic [DATA_W-1:0] rd_val;
    logic              drive;

    always_comb begin
        rd_val = '0;
        drive  = 1'b0;
        case (addr)
            OFF_SRA: begin
                if (mode == MODE_PS2) begin
                    drive  = 1'b1;
                    rd_val = sra_ps2;
                end else if (mode == MODE_M30) begin
                    drive  = 1'b1;
                    rd_val = sra_m30;
                end
            end
            OFF_SRB: begin
                if (mode == MODE_PS2) begin
                    drive  = 1'b1;
                    rd_val = srb_ps2;
                end else if (mode == MODE_M30) begin
                    drive  = 1'b1;
                    rd_val = srb_m30;
                end
            end
            OFF_DOR: begin
                drive  = 1'b1;
                rd_val = dor_q;
            end
            OFF_TDR: begin
                drive  = 1'b1;
                rd_val = {{TAPE_PAD{1'b0}}, tdr_q};
            end
            OFF_DIR: begin
                drive  = 1'b1;
                rd_val = dir_val;
            end
            default: begin
                drive  = 1'b0;
                rd_val = '0;
            end
        endcase
    end

    assign rdata     = drive ? rd_val : '0;
    assign rdata_oe  = rd_en & drive;
    assign dor_bits  = dor_q;
    assign data_rate = rate_q;
    assign precomp   = pcomp_q;
endmodule

// File: rtl/fdc_hostregs_chk.sv
module fdc_hostregs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic       fifo_acc,
    input logic [7:0] dor_bits,
    input logic       ctl_reset,
    input logic       low_power,
    input logic [1:0] data_rate
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dor_bits[2] |-> ctl_reset);

    p_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_reset && dor_bits[2] && !(wr_en && addr == 3'd2 && !wdata[2])
         && !(wr_en && addr == 3'd4 && wdata[7])) |=> !ctl_reset);

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4 && wdata[7]) |=> ctl_reset);

    p_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (addr == 3'd4 || addr == 3'd7)) |-> data_rate == $past(wdata[1:0]));

    p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && fifo_acc) |=> !low_power);

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_reset && low_power));

    p_ps2_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && mode == 2'd1 && addr == 3'd1) |-> rdata[7:6] == 2'b11);

    p_at_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == 2'd0 && addr <= 3'd1) |-> (!rdata_oe && rdata == 8'h00));

    p_dir_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && addr == 3'd7) |-> rdata[6:0] == 7'd0);
endmodule

bind fdc_hostregs fdc_hostregs_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .mode (mode),
    .addr (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wdata (wdata),
    .rdata (rdata),
    .rdata_oe (rdata_oe),
    .fifo_acc (fifo_acc),
    .dor_bits (dor_bits),
    .ctl_reset (ctl_reset),
    .low_power (low_power),
    .data_rate (data_rate)
);

// File: tb/fdc_hostregs_bench.sv
`timescale 1ns/1ps
module fdc_hostregs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       fifo_acc = 1'b0, int_req = 1'b0, dma_req = 1'b0;
    logic       drv_dir = 0, drv_wprot = 0, drv_index = 0, drv_hdsel = 0, drv_trk0 = 0;
    logic       drv_step = 0, drv_rdpulse = 0, drv_wrpulse = 0, drv_wgate = 0, drv_dskchg = 0;
    logic       dchg_force_en = 0, dchg_force_val = 0;
    logic [7:0] dor_bits;
    logic       ctl_reset, low_power;
    logic [1:0] data_rate;
    logic [2:0] precomp;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fdc_hostregs u_fdc_hostregs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .fifo_acc(fifo_acc),
        .int_req(int_req), .dma_req(dma_req), .drv_dir(drv_dir), .drv_wprot(drv_wprot),
        .drv_index(drv_index), .drv_hdsel(drv_hdsel), .drv_trk0(drv_trk0),
        .drv_step(drv_step), .drv_rdpulse(drv_rdpulse), .drv_wrpulse(drv_wrpulse),
        .drv_wgate(drv_wgate), .drv_dskchg(drv_dskchg), .dchg_force_en(dchg_force_en),
        .dchg_force_val(dchg_force_val), .dor_bits(dor_bits), .ctl_reset(ctl_reset),
        .low_power(low_power), .data_rate(data_rate), .precomp(precomp)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] adr;
        logic [1:0] md;
        logic [7:0] dat;
        logic       oe;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd2, 2'd0, 8'h00, 1'b1, 4'd1},
        '{1'b1, 3'd2, 2'd0, 8'h1D, 1'b0, 4'd2},
        '{1'b0, 3'd2, 2'd0, 8'h1D, 1'b1, 4'd2},
        '{1'b0, 3'd1, 2'd1, 8'hE1, 1'b1, 4'd6},
        '{1'b0, 3'd1, 2'd0, 8'h00, 1'b0, 4'd9},
        '{1'b0, 3'd0, 2'd0, 8'h00, 1'b0, 4'd9},
        '{1'b0, 3'd0, 2'd1, 8'h16, 1'b1, 4'd8},
        '{1'b0, 3'd0, 2'd2, 8'h09, 1'b1, 4'd8},
        '{1'b1, 3'd3, 2'd0, 8'hFF, 1'b0, 4'd11},
        '{1'b0, 3'd3, 2'd0, 8'h03, 1'b1, 4'd11},
        '{1'b0, 3'd7, 2'd1, 8'h80, 1'b1, 4'd10},
        '{1'b0, 3'd5, 2'd1, 8'h00, 1'b0, 4'd9},
        '{1'b0, 3'd4, 2'd2, 8'h00, 1'b0, 4'd9},
        '{1'b0, 3'd1, 2'd2, 8'h00, 1'b1, 4'd7}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, input logic [1:0] m,
                           output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; mode = m; rd_en = 1'b1;
        #1;
        d = rdata; oe = rdata_oe;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [1:0] m,
                          input logic [7:0] exp);
        logic [7:0] d;
        logic       oe;
        do_read(a, m, d, oe);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset values
        check("R1 ctl_reset", {7'b0, ctl_reset}, 8'h01);
        check("R1 low_power", {7'b0, low_power}, 8'h00);
        check("R1 data_rate", {6'b0, data_rate}, 8'h02);
        check("R1 precomp", {5'b0, precomp}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            mode = TBL[i].md;
            if (TBL[i].wr) begin
                do_write(TBL[i].adr, TBL[i].dat);
            end else begin
                do_read(TBL[i].adr, TBL[i].md, d, oe);
                check($sformatf("R%0d table %0d data", TBL[i].req, i), d, TBL[i].dat);
                check($sformatf("R%0d table %0d oe", TBL[i].req, i), {7'b0, oe}, {7'b0, TBL[i].oe});
            end
        end
        check("R2 released", {7'b0, ctl_reset}, 8'h00);

        // R2: held reset keeps other state
        do_write(3'd2, 8'h19);
        check("R2 hold", {7'b0, ctl_reset}, 8'h01);
        tick(3);
        check("R2 still held", {7'b0, ctl_reset}, 8'h01);
        check("R2 rate kept", {6'b0, data_rate}, 8'h02);
        rd_chk("R2 tdr kept", 3'd3, 2'd0, 8'h03);
        rd_chk("R2 dor bits", 3'd2, 2'd0, 8'h19);
        do_write(3'd2, 8'h1D);
        check("R2 release", {7'b0, ctl_reset}, 8'h00);

        // R3: self-clearing pulse
        do_write(3'd4, 8'h81);
        check("R3 pulse high", {7'b0, ctl_reset}, 8'h01);
        check("R3 rate", {6'b0, data_rate}, 8'h01);
        tick(1);
        check("R3 pulse cleared", {7'b0, ctl_reset}, 8'h00);
        rd_chk("R3 dor kept", 3'd2, 2'd0, 8'h1D);
        rd_chk("R11 tdr after reset", 3'd3, 2'd0, 8'h03);

        // R4: last writer sets rate
        do_write(3'd7, 8'h03);
        check("R4 ccr rate", {6'b0, data_rate}, 8'h03);
        do_write(3'd4, 8'h1C);
        check("R4 dsr rate", {6'b0, data_rate}, 8'h00);
        check("R4 precomp", {5'b0, precomp}, 8'h07);
        do_write(3'd7, 8'h02);
        check("R4 ccr again", {6'b0, data_rate}, 8'h02);
        check("R4 precomp kept", {5'b0, precomp}, 8'h07);

        // R5: low power entry and exits
        do_write(3'd4, 8'h42);
        check("R5 enter", {7'b0, low_power}, 8'h01);
        tick(3);
        check("R5 stays", {7'b0, low_power}, 8'h01);
        fifo_acc = 1'b1;
        tick(1);
        fifo_acc = 1'b0;
        check("R5 fifo wake", {7'b0, low_power}, 8'h00);
        do_write(3'd4, 8'h42);
        do_write(3'd2, 8'h19);
        check("R5 dor reset exit", {7'b0, low_power}, 8'h00);
        do_write(3'd2, 8'h1D);
        check("R5 stays off", {7'b0, low_power}, 8'h00);
        do_write(3'd4, 8'h42);
        do_write(3'd4, 8'h82);
        check("R5 dsr reset exit", {7'b0, low_power}, 8'h00);
        tick(1);

        // R6: PS/2 toggles
        drv_rdpulse = 1; tick(4);
        rd_chk("R6 rise no toggle", 3'd1, 2'd1, 8'hE1);
        drv_rdpulse = 0; tick(4);
        rd_chk("R6 rd toggle", 3'd1, 2'd1, 8'hE9);
        drv_rdpulse = 1; tick(4); drv_rdpulse = 0; tick(4);
        rd_chk("R6 rd toggle back", 3'd1, 2'd1, 8'hE1);
        drv_wrpulse = 1; tick(4); drv_wrpulse = 0; tick(4);
        rd_chk("R6 wr toggle", 3'd1, 2'd1, 8'hF1);
        drv_wgate = 1; tick(4);
        rd_chk("R6 wgate level", 3'd1, 2'd1, 8'hF5);
        drv_wgate = 0; tick(4);
        rd_chk("R6 wgate low", 3'd1, 2'd1, 8'hF1);

        // R7: Model 30 latches
        rd_chk("R10 clear read", 3'd7, 2'd2, 8'h80);
        rd_chk("R7 cleared", 3'd1, 2'd2, 8'h00);
        drv_wgate = 1; tick(4); drv_wgate = 0; tick(4);
        rd_chk("R7 wgate latch", 3'd1, 2'd2, 8'h01);
        drv_rdpulse = 1; tick(4);
        rd_chk("R7 rd rise only", 3'd1, 2'd2, 8'h01);
        drv_rdpulse = 0; tick(4);
        rd_chk("R7 rd fall latch", 3'd1, 2'd2, 8'h03);
        drv_step = 1; tick(4); drv_step = 0; tick(4);
        rd_chk("R7 step latch", 3'd0, 2'd2, 8'h29);
        rd_chk("R7 dir read", 3'd7, 2'd2, 8'h80);
        rd_chk("R7 srb clear", 3'd1, 2'd2, 8'h00);
        rd_chk("R7 sra clear", 3'd0, 2'd2, 8'h09);
        drv_wrpulse = 1; tick(4); drv_wrpulse = 0; tick(4);
        rd_chk("R7 wr latch", 3'd1, 2'd2, 8'h04);
        do_write(3'd4, 8'h82);
        tick(1);
        rd_chk("R7 sw reset clear", 3'd1, 2'd2, 8'h00);

        // R8: status A polarity
        drv_dir = 1; drv_wprot = 1; drv_index = 1; drv_hdsel = 1; drv_trk0 = 1;
        int_req = 1;
        tick(4);
        rd_chk("R8 ps2 sra", 3'd0, 2'd1, 8'h89);
        rd_chk("R8 m30 sra", 3'd0, 2'd2, 8'h96);
        int_req = 0;

        // R10: disk change and force
        drv_dskchg = 1; tick(4);
        rd_chk("R10 dskchg high", 3'd7, 2'd0, 8'h00);
        dchg_force_en = 1; dchg_force_val = 1;
        rd_chk("R10 forced one", 3'd7, 2'd0, 8'h80);
        dchg_force_val = 0;
        rd_chk("R10 forced zero", 3'd7, 2'd0, 8'h00);

        // R11: tape select upper bits read zero
        do_write(3'd3, 8'hFE);
        rd_chk("R11 tdr mask", 3'd3, 2'd0, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule